// File: doc/BRIEF.md
# Interrupt Status Unit with Clear-on-Read Sources

This block gathers the interrupt causes of a serial bus controller. Twelve sources feed a raw status word. Ten of them are sticky: a one-cycle pulse sets the bit, and the bit stays set until software clears it. The other two are level sources, receive-full and transmit-empty, and they simply mirror their threshold condition. A mask word selects which raw bits reach the masked status word. The OR of the masked bits drives a registered interrupt line.

Software clears sticky bits by reading. Each sticky source has its own clear address, and a read there clears that bit alone. A read of the combined clear address clears every sticky bit. An abort pulse also ORs a cause vector into an abort-cause register. That register is wiped when the abort bit is cleared, so software must read the cause before it clears the abort. When the block is disabled, all sticky state is held at zero.

Top module: `intr_status_unit`

## Requirements
- R1: A pulse on `srcIn[i]` for a sticky source sets raw status bit i at the next clock edge. Sticky positions are 0 rx underflow, 1 rx overflow, 3 tx overflow, 5 read request, 6 tx abort, 7 rx done, 8 activity, 9 stop seen, 10 start seen and 11 general call. Raw status is read at word address 0, in bits 11:0.
- R2: Bits 2 (rx full) and 4 (tx empty) of raw status equal `srcIn[2]` and `srcIn[4]` in the same cycle. No clear read changes them or any other bit.
- R3: The mask is read and written at address 1, in bits 11:0. A read of address 2 returns raw status ANDed with the mask.
- R4: After reset, all sticky bits, the abort cause and `irq` are 0, and the mask is 12'h254, which enables bits 2, 4, 6 and 9.
- R5: A read of address 5+i clears sticky bit i and leaves every other bit unchanged.
- R6: A read of address 4 clears all sticky bits and the abort cause at the next edge.
- R7: Each abort pulse (bit 6) ORs `causeIn` into the abort-cause register, which is read at address 3. A read of address 11, the abort clear, also zeroes this register. An abort pulse that arrives in the same cycle as that read leaves exactly the new `causeIn`.
- R8: When a sticky event arrives in the same cycle as a read that would clear it, the bit is set after the edge.
- R9: `irq` equals the OR of (raw status AND mask) as sampled at the previous clock edge.
- R10: While `enable` is low, sticky bits and the abort cause are zero at the next edge, and event pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Block enable; when low, sticky state is held cleared |
| regRdEn | input | 1 | Register read strobe; clear addresses act on it |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 5 | Word address |
| regWrData | input | 32 | Write data; bits 11:0 are used for the mask |
| rdData | output | 32 | Combinational read data for `regAddr` |
| srcIn | input | 12 | Event pulses for sticky sources, conditions for level sources |
| causeIn | input | 16 | Abort cause vector captured on an abort pulse |
| irq | output | 1 | Registered interrupt request |

## Verification
A sticky bit that is stuck, or that is cleared by the wrong address, shows up at the next read of address 0 or 2. Through `irq` it shows one cycle later whenever the bit is enabled by the mask. A broken priority between an event and its clear is caught at the read after the colliding cycle. A cause register that survives its clear is caught at the next read of address 3. Random traffic mixes pulses, clears, mask writes and disable cycles, and the outputs are compared against a cycle model on every cycle.

// File: rtl/intr_status_pkg.sv
package intr_status_pkg;
  localparam int NUM_SRC = 12;
  localparam int ADDR_W  = 5;
  localparam int DATA_W  = 32;
  localparam int CAUSE_W = 16;
  localparam int ABORT_BIT = 6;
  localparam logic [NUM_SRC-1:0] LEVEL_SRC = 12'h014;
  localparam logic [NUM_SRC-1:0] STICKY_SRC = ~LEVEL_SRC;
  localparam logic [NUM_SRC-1:0] MASK_INIT = 12'h254;

  localparam logic [ADDR_W-1:0] ADR_RAW      = 5'd0;
  localparam logic [ADDR_W-1:0] ADR_MASK     = 5'd1;
  localparam logic [ADDR_W-1:0] ADR_MASKED   = 5'd2;
  localparam logic [ADDR_W-1:0] ADR_CAUSE    = 5'd3;
  localparam logic [ADDR_W-1:0] ADR_CLR_ALL  = 5'd4;
  localparam logic [ADDR_W-1:0] ADR_CLR_BASE = 5'd5;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_RAW, SEL_MASK, SEL_MASKED, SEL_CAUSE
  } rdSel_e;

  typedef struct packed {
    logic [NUM_SRC-1:0] clrVec;
    logic               clrCause;
    logic               wrMask;
    rdSel_e             rdSel;
  } strobe_t;
endpackage

// File: rtl/intr_status_ctrl.sv
module intr_status_ctrl
  import intr_status_pkg::*;
(
  input  logic              regRdEn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output strobe_t           strb
);
  logic [NUM_SRC-1:0] clrHit;
  logic               causeHit;
  rdSel_e             sel;

  always_comb begin
    clrHit   = '0;
    causeHit = 1'b0;
    sel      = SEL_NONE;
    if (regRdEn) begin
      case (regAddr)
        ADR_RAW:    sel = SEL_RAW;
        ADR_MASK:   sel = SEL_MASK;
        ADR_MASKED: sel = SEL_MASKED;
        ADR_CAUSE:  sel = SEL_CAUSE;
        ADR_CLR_ALL: begin
          clrHit   = STICKY_SRC;
          causeHit = 1'b1;
        end
        default: ;
      endcase
      for (int i = 0; i < NUM_SRC; i++) begin
        if (regAddr == ADR_CLR_BASE + ADDR_W'(i)) begin
          clrHit[i] = STICKY_SRC[i];
          if (i == ABORT_BIT) causeHit = 1'b1;
        end
      end
    end
  end

  always_comb begin
    strb.clrVec   = clrHit;
    strb.clrCause = causeHit;
    strb.wrMask   = regWrEn && (regAddr == ADR_MASK);
    strb.rdSel    = sel;
  end
endmodule

// File: rtl/intr_status_dp.sv
module intr_status_dp
  import intr_status_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [CAUSE_W-1:0] causeIn,
  input  logic [DATA_W-1:0]  regWrData,
  input  strobe_t            strb,
  output logic [NUM_SRC-1:0] rawStatus,
  output logic [NUM_SRC-1:0] maskReg,
  output logic [CAUSE_W-1:0] abortCause,
  output logic [DATA_W-1:0]  rdData,
  output logic               irq
);
  localparam int PAD_SRC   = DATA_W - NUM_SRC;
  localparam int PAD_CAUSE = DATA_W - CAUSE_W;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (LEVEL_SRC[i]) begin : g_level
      logic unusedClr;
      assign unusedClr    = strb.clrVec[i];
      assign rawStatus[i] = srcIn[i];
    end else begin : g_sticky
      logic bitQ;
      always_ff @(posedge clk) begin
        if (!rstN)               bitQ <= 1'b0;
        else if (!enable)        bitQ <= 1'b0;
        else if (srcIn[i])       bitQ <= 1'b1;
        else if (strb.clrVec[i]) bitQ <= 1'b0;
      end
      assign rawStatus[i] = bitQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 abortCause <= '0;
    else if (!enable)          abortCause <= '0;
    else if (srcIn[ABORT_BIT]) abortCause <= (strb.clrCause ? '0 : abortCause) | causeIn;
    else if (strb.clrCause)    abortCause <= '0;
  end

  logic unusedWrHi;
  assign unusedWrHi = ^regWrData[DATA_W-1:NUM_SRC];

  always_ff @(posedge clk) begin
    if (!rstN)            maskReg <= MASK_INIT;
    else if (strb.wrMask) maskReg <= regWrData[NUM_SRC-1:0];
  end

  logic [NUM_SRC-1:0] maskedStatus;
  assign maskedStatus = rawStatus & maskReg;

  always_ff @(posedge clk) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= |maskedStatus;
  end

  always_comb begin
    case (strb.rdSel)
      SEL_RAW:    rdData = {{PAD_SRC{1'b0}}, rawStatus};
      SEL_MASK:   rdData = {{PAD_SRC{1'b0}}, maskReg};
      SEL_MASKED: rdData = {{PAD_SRC{1'b0}}, maskedStatus};
      SEL_CAUSE:  rdData = {{PAD_CAUSE{1'b0}}, abortCause};
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/intr_status_unit.sv
module intr_status_unit
  import intr_status_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               regRdEn,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [CAUSE_W-1:0] causeIn,
  output logic               irq
);
  strobe_t            strb;
  logic [NUM_SRC-1:0] rawStatus;
  logic [NUM_SRC-1:0] maskReg;
  logic [CAUSE_W-1:0] abortCause;

  intr_status_ctrl ctrl_i (
    .regRdEn (regRdEn),
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strb    (strb)
  );

  intr_status_dp dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .srcIn      (srcIn),
    .causeIn    (causeIn),
    .regWrData  (regWrData),
    .strb       (strb),
    .rawStatus  (rawStatus),
    .maskReg    (maskReg),
    .abortCause (abortCause),
    .rdData     (rdData),
    .irq        (irq)
  );
endmodule

// File: rtl/intr_status_chk.sv
module intr_status_chk
  import intr_status_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               enable,
  input logic               regRdEn,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [NUM_SRC-1:0] srcIn,
  input logic [NUM_SRC-1:0] rawStatus,
  input logic [NUM_SRC-1:0] maskReg,
  input logic [CAUSE_W-1:0] abortCause,
  input logic [DATA_W-1:0]  rdData,
  input logic               irq
);
  logic pastValid;
  always_ff @(posedge clk) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  // R1
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && |(srcIn & STICKY_SRC)) |=>
      ((rawStatus & $past(srcIn & STICKY_SRC)) == $past(srcIn & STICKY_SRC)));

  // R3
  masked_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == ADR_MASKED) |-> (rdData[NUM_SRC-1:0] == (rawStatus & maskReg)));

  // R6
  clear_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == ADR_CLR_ALL && (srcIn & STICKY_SRC) == '0) |=>
      ((rawStatus & STICKY_SRC) == '0 && abortCause == '0));

  // R7
  cause_wipe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == ADR_CLR_BASE + ADDR_W'(ABORT_BIT) && !srcIn[ABORT_BIT]) |=>
      (abortCause == '0));

  // R8
  event_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && regRdEn && regAddr == ADR_CLR_ALL && |(srcIn & STICKY_SRC)) |=>
      ((rawStatus & $past(srcIn & STICKY_SRC)) == $past(srcIn & STICKY_SRC)));

  // R9
  irq_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |=> (irq == $past(|(rawStatus & maskReg))));

  // R10
  disabled_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!enable) |=> ((rawStatus & STICKY_SRC) == '0 && abortCause == '0));
endmodule

bind intr_status_unit intr_status_chk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .enable     (enable),
  .regRdEn    (regRdEn),
  .regAddr    (regAddr),
  .srcIn      (srcIn),
  .rawStatus  (rawStatus),
  .maskReg    (maskReg),
  .abortCause (abortCause),
  .rdData     (rdData),
  .irq        (irq)
);

// File: tb/intr_status_unit_tb_top.sv
module intr_status_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        regRdEn = 1'b0;
  logic        regWrEn = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] rdData;
  logic [11:0] srcIn = '0;
  logic [15:0] causeIn = '0;
  logic        irq;

  localparam logic [11:0] LVL = 12'h014;
  localparam logic [11:0] STK = 12'hFEB;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [11:0] mSticky;
  logic [11:0] mMask;
  logic [15:0] mCause;
  logic        mIrq;

  always #10 clk = ~clk;

  intr_status_unit dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .regRdEn(regRdEn),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .rdData(rdData), .srcIn(srcIn), .causeIn(causeIn), .irq(irq)
  );

  function automatic logic [11:0] rawNow(input logic [11:0] src);
    return (mSticky & STK) | (src & LVL);
  endfunction

  function automatic logic [31:0] expRead(input logic [4:0] a, input logic [11:0] src);
    case (a)
      5'd0: return {20'd0, rawNow(src)};
      5'd1: return {20'd0, mMask};
      5'd2: return {20'd0, rawNow(src) & mMask};
      5'd3: return {16'd0, mCause};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit en, input bit rd, input bit wr, input logic [4:0] a,
                     input logic [31:0] wd, input logic [11:0] src,
                     input logic [15:0] cz, input string tag);
    logic [11:0] clr;
    bit clrCz;
    @(negedge clk);
    enable = en; regRdEn = rd; regWrEn = wr; regAddr = a;
    regWrData = wd; srcIn = src; causeIn = cz;
    #1;
    if (rd) check(tag, rdData, expRead(a, src));
    check("R9", {31'd0, irq}, {31'd0, mIrq});
    clr = '0; clrCz = 0;
    if (rd && a == 5'd4) begin clr = STK; clrCz = 1; end
    if (rd && a >= 5'd5 && a <= 5'd16) begin
      clr[a - 5'd5] = 1'b1;
      if (a == 5'd11) clrCz = 1;
    end
    mIrq = |(rawNow(src) & mMask);
    if (!en) begin
      mSticky = '0; mCause = '0;
    end else begin
      if (src[6]) mCause = (clrCz ? 16'd0 : mCause) | cz;
      else if (clrCz) mCause = '0;
      mSticky = ((mSticky & ~clr) | src) & STK;
    end
    if (wr && a == 5'd1) mMask = wd[11:0];
  endtask

  initial begin
    #3000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    mSticky = '0; mMask = 12'h254; mCause = '0; mIrq = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R4 reset state
    cyc(1, 1, 0, 5'd0, 0, 12'h000, 0, "R4");
    cyc(1, 1, 0, 5'd1, 0, 12'h000, 0, "R4");
    cyc(1, 1, 0, 5'd3, 0, 12'h000, 0, "R4");
    // R1 set every sticky source
    cyc(1, 0, 0, 5'd0, 0, STK, 16'h0009, "R1");
    cyc(1, 1, 0, 5'd0, 0, 12'h000, 0, "R1");
    // R2 level sources follow input and ignore clears
    cyc(1, 1, 0, 5'd0, 0, LVL, 0, "R2");
    cyc(1, 1, 0, 5'd7, 0, LVL, 0, "R2");
    cyc(1, 1, 0, 5'd0, 0, 12'h010, 0, "R2");
    // R5 single clear
    cyc(1, 1, 0, 5'd5, 0, 12'h000, 0, "R5");
    cyc(1, 1, 0, 5'd0, 0, 12'h000, 0, "R5");
    cyc(1, 1, 0, 5'd14, 0, 12'h000, 0, "R5");
    cyc(1, 1, 0, 5'd0, 0, 12'h000, 0, "R5");
    // R3 mask write and masked read
    cyc(1, 0, 1, 5'd1, 32'hFFFF_F001, 12'h000, 0, "R3");
    cyc(1, 1, 0, 5'd2, 0, 12'h000, 0, "R3");
    cyc(1, 0, 1, 5'd1, 32'h0000_0800, 12'h000, 0, "R3");
    cyc(1, 1, 0, 5'd2, 0, 12'h000, 0, "R3");
    cyc(1, 1, 0, 5'd1, 0, 12'h000, 0, "R3");
    // R7 abort cause accumulation and wipe
    cyc(1, 0, 0, 5'd0, 0, 12'h040, 16'h0100, "R7");
    cyc(1, 1, 0, 5'd3, 0, 12'h000, 0, "R7");
    cyc(1, 1, 0, 5'd11, 0, 12'h000, 0, "R7");
    cyc(1, 1, 0, 5'd3, 0, 12'h000, 0, "R7");
    cyc(1, 1, 0, 5'd0, 0, 12'h000, 0, "R7");
    cyc(1, 1, 0, 5'd11, 0, 12'h040, 16'h0020, "R7");
    cyc(1, 1, 0, 5'd3, 0, 12'h000, 0, "R7");
    // R8 event beats its own clear
    cyc(1, 1, 0, 5'd14, 0, 12'h200, 0, "R8");
    cyc(1, 1, 0, 5'd0, 0, 12'h000, 0, "R8");
    // R6 combined clear, with a colliding event (R8)
    cyc(1, 1, 0, 5'd4, 0, 12'h008, 0, "R6");
    cyc(1, 1, 0, 5'd0, 0, 12'h000, 0, "R6");
    cyc(1, 1, 0, 5'd3, 0, 12'h000, 0, "R6");
    // R10 disable wipes and ignores pulses
    cyc(1, 0, 0, 5'd0, 0, STK, 16'hFFFF, "R10");
    cyc(0, 0, 0, 5'd0, 0, STK, 16'hFFFF, "R10");
    cyc(0, 1, 0, 5'd0, 0, 12'h000, 0, "R10");
    cyc(0, 1, 0, 5'd3, 0, 12'h000, 0, "R10");
    cyc(1, 0, 1, 5'd1, 32'h254, 12'h000, 0, "R3");
    // random mix
    void'($urandom(32'd4242));
    for (int n = 0; n < 4000; n++) begin
      logic [4:0] a;
      logic [11:0] s;
      bit rd, wr, en;
      string tag;
      a  = 5'($urandom % 18);
      rd = ($urandom % 2) == 0;
      wr = ($urandom % 10) == 0;
      en = ($urandom % 40) != 0;
      s  = 12'($urandom & $urandom & $urandom);
      case (a)
        5'd0: tag = "R1";
        5'd1: tag = "R3";
        5'd2: tag = "R3";
        5'd3: tag = "R7";
        default: tag = "R5";
      endcase
      cyc(en, rd, wr, a, $urandom, s, 16'($urandom), tag);
    end
    cyc(1, 1, 0, 5'd0, 0, 12'h000, 0, "R1");
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule